// File: doc/BRIEF.md
# Lockable Modulo-N Feedback Divider

This block sits in the feedback path of a frequency-synthesis loop. It divides the oscillator-side clock by a programmable ratio N and emits a single-cycle pulse once every N input cycles. N is a 12-bit multiplier held in two byte-wide registers. The low register carries bits 7:0. The lower nibble of the high register carries bits 11:8, and its upper nibble is not implemented. Software programs the ratio through a small byte bus while the loop is off. Once the loop-enable input is high, the ratio is frozen: bus writes are dropped, so the loop never sees its divide ratio change mid-lock.

A stored ratio of zero is treated as a ratio of one. The ratio actually in use is exported on a registered output so the surrounding clock logic can observe it. While the loop is disabled, the down-counter waits at its reload value and no pulses appear. When the loop is enabled, the first pulse arrives exactly N cycles later. The register bus and the divider share one clock, and every rising edge counts as one oscillator edge.

Top module: `mfd_feedback_divider`

## Requirements
- R1: After a synchronous reset, the low register reads 0x40, the high register reads 0x00, `div_value` is 64 and `div_pulse` is 0.
- R2: `bus_sel_hi`=1 addresses the high register and `bus_sel_hi`=0 the low register. The high register stores only write-data bits 3:0, as multiplier bits 11:8. Its read bits 7:4 are always 0, whatever was written.
- R3: While `pll_en` is 1, writes to either register are ignored. Both the readback and `div_value` keep their previous values.
- R4: `bus_rdata` shows the addressed register combinationally while `bus_rd` is 1, and is 0x00 while `bus_rd` is 0.
- R5: The effective ratio is the stored multiplier, or 1 when the stored multiplier is 0. It appears on `div_value` one clock after the register is written.
- R6: With `pll_en` held at 1 from some rising edge onward, `div_pulse` is high for one cycle after every N-th edge. This holds at N = 1 (high every cycle), N = 2, N = 64 and N = 4095, with the first pulse after the N-th enabled edge.
- R7: While `pll_en` is 0, `div_pulse` stays 0. The count restarts from the full ratio at the next enable, whatever it had reached before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the divider (oscillator side) |
| rst | input | 1 | Synchronous active-high reset |
| pll_en | input | 1 | Loop enable: runs the divider and locks the registers |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read enable |
| bus_sel_hi | input | 1 | Register select: 1 high, 0 low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| div_value | output | 12 | Effective divide ratio in use |
| div_pulse | output | 1 | Single-cycle pulse once per N input cycles |

## Verification
The bench checks the zero ratio. A design that passed zero straight to the counter would wrap through 4096 states, or stall, instead of pulsing every cycle. It also checks the extreme ratios 1 and 4095, where an off-by-one in the terminal count would shift every pulse by one cycle. Writes made while the loop is enabled must leave both the readback and the exported ratio intact; a missing lock would show the new byte at once. Writes of all ones to the high register must read back with a clear upper nibble, and the bench checks that no pulse leaks out while the loop is disabled.

// File: rtl/mfd_pkg.sv
package mfd_pkg;
  localparam int unsigned BUS_W_DEF = 8;
  localparam int unsigned MUL_W_DEF = 12;

  typedef enum logic {
    SEL_LO = 1'b0,
    SEL_HI = 1'b1
  } mfd_sel_e;
endpackage

// File: rtl/mfd_mul_regs.sv
module mfd_mul_regs
  import mfd_pkg::*;
#(
  parameter int unsigned BUS_W = BUS_W_DEF,
  parameter int unsigned MUL_W = MUL_W_DEF,
  parameter logic [MUL_W-1:0] MUL_RESET = MUL_W'(64)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock,
  input  logic             wr,
  input  logic             rd,
  input  mfd_sel_e         sel,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  output logic [MUL_W-1:0] mul
);
  localparam int unsigned HI_W = MUL_W - BUS_W;
  localparam int unsigned PAD_W = BUS_W - HI_W;

  logic [BUS_W-1:0] lo_q;
  logic [HI_W-1:0]  hi_q;
  logic [BUS_W-1:0] hi_view;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= MUL_RESET[BUS_W-1:0];
      hi_q <= MUL_RESET[MUL_W-1:BUS_W];
    end else if (wr && !lock) begin
      if (sel == SEL_HI) hi_q <= wdata[HI_W-1:0];
      else               lo_q <= wdata;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign hi_view = {{PAD_W{1'b0}}, hi_q};
    end else begin : g_nopad
      assign hi_view = hi_q[BUS_W-1:0];
    end
  endgenerate

  always_comb begin
    if (!rd)                rdata = '0;
    else if (sel == SEL_HI) rdata = hi_view;
    else                    rdata = lo_q;
  end

  assign mul = {hi_q, lo_q};
endmodule

// File: rtl/mfd_eff_map.sv
module mfd_eff_map #(
  parameter int unsigned MUL_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MUL_W-1:0] mul,
  output logic [MUL_W-1:0] eff,
  output logic [MUL_W-1:0] eff_q
);
  localparam logic [MUL_W-1:0] ONE = MUL_W'(1);
  localparam logic [MUL_W-1:0] RST_EFF = MUL_W'(64);

  always_comb begin
    eff = (mul == '0) ? ONE : mul;
  end

  always_ff @(posedge clk) begin
    if (rst) eff_q <= RST_EFF;
    else     eff_q <= eff;
  end
endmodule

// File: rtl/mfd_modulo_counter.sv
module mfd_modulo_counter #(
  parameter int unsigned MUL_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [MUL_W-1:0] reload,
  output logic             pulse
);
  localparam logic [MUL_W-1:0] TERM = MUL_W'(1);

  logic [MUL_W-1:0] cnt_q;
  logic             at_term;

  assign at_term = (cnt_q == TERM);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= reload;
      pulse <= 1'b0;
    end else if (!run) begin
      cnt_q <= reload;
      pulse <= 1'b0;
    end else if (at_term) begin
      cnt_q <= reload;
      pulse <= 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/mfd_feedback_divider.sv
module mfd_feedback_divider
  import mfd_pkg::*;
#(
  parameter int unsigned BUS_W = BUS_W_DEF,
  parameter int unsigned MUL_W = MUL_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pll_en,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_sel_hi,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic [MUL_W-1:0] div_value,
  output logic             div_pulse
);
  logic [MUL_W-1:0] mul_q;
  logic [MUL_W-1:0] eff_n;
  mfd_sel_e         sel;

  assign sel = bus_sel_hi ? SEL_HI : SEL_LO;

  mfd_mul_regs #(
    .BUS_W(BUS_W), .MUL_W(MUL_W), .MUL_RESET(MUL_W'(64))
  ) u_regs (
    .clk(clk), .rst(rst), .lock(pll_en), .wr(bus_wr), .rd(bus_rd),
    .sel(sel), .wdata(bus_wdata), .rdata(bus_rdata), .mul(mul_q)
  );

  mfd_eff_map #(.MUL_W(MUL_W)) u_map (
    .clk(clk), .rst(rst), .mul(mul_q), .eff(eff_n), .eff_q(div_value)
  );

  mfd_modulo_counter #(.MUL_W(MUL_W)) u_cnt (
    .clk(clk), .rst(rst), .run(pll_en), .reload(eff_n), .pulse(div_pulse)
  );
endmodule

// File: rtl/mfd_checker.sv
module mfd_checker #(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned MUL_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             pll_en,
  input logic             bus_rd,
  input logic             bus_sel_hi,
  input logic [BUS_W-1:0] bus_rdata,
  input logic [MUL_W-1:0] mul,
  input logic [MUL_W-1:0] div_value,
  input logic             div_pulse
);
  localparam int unsigned HI_W = MUL_W - BUS_W;

  AST_LOCKED_MUL_STABLE: assert property (@(posedge clk) disable iff (rst)
    $past(pll_en) |-> $stable(mul)); // R3

  AST_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_sel_hi) |-> (bus_rdata[BUS_W-1:HI_W] == '0)); // R2

  AST_RATIO_NONZERO: assert property (@(posedge clk) disable iff (rst)
    div_value != '0); // R5

  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> $past(pll_en)); // R7

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |-> (bus_rdata == '0)); // R4
endmodule

bind mfd_feedback_divider mfd_checker #(.BUS_W(BUS_W), .MUL_W(MUL_W)) u_chk (
  .clk(clk), .rst(rst), .pll_en(pll_en), .bus_rd(bus_rd),
  .bus_sel_hi(bus_sel_hi), .bus_rdata(bus_rdata), .mul(mul_q),
  .div_value(div_value), .div_pulse(div_pulse)
);

// File: tb/mfd_feedback_divider_test.sv
module mfd_feedback_divider_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pll_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_sel_hi = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [11:0] div_value;
  logic        div_pulse;

  int vectors = 0;
  int miscompares = 0;
  int exp_q[$];
  int since = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mfd_feedback_divider uut (
    .clk(clk), .rst(rst), .pll_en(pll_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel_hi(bus_sel_hi), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .div_value(div_value), .div_pulse(div_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  task automatic bus_write(input bit hi, input logic [7:0] d);
    @(negedge clk);
    bus_sel_hi = hi; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_check(input bit hi, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_sel_hi = hi; bus_rd = 1'b1;
    #1;
    chk(bus_rdata == exp, req, bus_rdata, exp);
    bus_rd = 1'b0;
  endtask

  task automatic ratio_check(input int exp, input string req);
    @(negedge clk);
    @(negedge clk);
    chk(div_value == 12'(exp), req, div_value, exp);
  endtask

  // driver: queue K expected intervals of N, enable for exactly K*N edges
  task automatic run_ratio(input int n, input int k);
    for (int i = 0; i < k; i++) exp_q.push_back(n);
    @(negedge clk);
    pll_en = 1'b1;
    repeat (n * k) @(posedge clk);
    @(negedge clk);
    pll_en = 1'b0;
    chk(exp_q.size() == 0, "R6 pulses owed", exp_q.size(), 0);
    exp_q.delete();
  endtask

  // monitor: measures edges between pulses while enabled
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      if (pll_en) begin
        since++;
        if (div_pulse) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R6 unexpected pulse", since, 0);
          end else begin
            int e;
            e = exp_q.pop_front();
            chk(since == e, "R6 pulse spacing", since, e);
          end
          since = 0;
        end
      end else begin
        since = 0;
        if (div_pulse) chk(1'b0, "R7 pulse while disabled", 1, 0);
      end
    end
  end

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog", 1, 0);
    finish_run();
  end

  initial begin
    int pulses;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    #1;
    chk(div_value == 12'd64, "R1 div_value", div_value, 64);
    chk(div_pulse == 1'b0, "R1 div_pulse", div_pulse, 0);
    bus_check(1'b0, 8'h40, "R1 low reset");
    bus_check(1'b1, 8'h00, "R1 high reset");
    // R4 idle read
    @(negedge clk); bus_sel_hi = 1'b0; #1;
    chk(bus_rdata == 8'h00, "R4 idle read", bus_rdata, 0);
    // R6 N=64
    run_ratio(64, 3);
    // R2 unimplemented nibble
    bus_write(1'b1, 8'hFF);
    bus_check(1'b1, 8'h0F, "R2 high nibble");
    ratio_check(12'hF40, "R2 high maps to bits 11:8");
    bus_write(1'b1, 8'h00);
    // R6 N=2
    bus_write(1'b0, 8'h02);
    bus_check(1'b0, 8'h02, "R2 low readback");
    ratio_check(2, "R5 ratio 2");
    run_ratio(2, 5);
    // R5 zero maps to one
    bus_write(1'b0, 8'h00);
    bus_check(1'b0, 8'h00, "R5 zero stored");
    ratio_check(1, "R5 zero as one");
    run_ratio(1, 6);
    // R6 N=4095
    bus_write(1'b0, 8'hFF);
    bus_write(1'b1, 8'h0F);
    ratio_check(4095, "R5 ratio 4095");
    run_ratio(4095, 3);
    // R3 lock while enabled
    @(negedge clk); pll_en = 1'b1;
    bus_write(1'b0, 8'h12);
    bus_write(1'b1, 8'h03);
    bus_check(1'b0, 8'hFF, "R3 low locked");
    bus_check(1'b1, 8'h0F, "R3 high locked");
    ratio_check(4095, "R3 ratio locked");
    @(negedge clk); pll_en = 1'b0;
    // R7 disabled: no pulses, fresh count on re-enable
    bus_write(1'b0, 8'h03);
    bus_write(1'b1, 8'h00);
    pulses = 0;
    for (int i = 0; i < 50; i++) begin
      @(posedge clk); #2;
      if (div_pulse) pulses++;
    end
    chk(pulses == 0, "R7 idle pulses", pulses, 0);
    run_ratio(3, 4);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule